// File: doc/BRIEF.md
# PCIe Configuration Request Engine

This block turns one host configuration access (read or write, of 1, 2 or 4 bytes) into a PCIe configuration request TLP. It issues that TLP on a root-port transmit register interface and then polls a completion interface for the reply. It forms the three header dwords itself and picks Type 0 or Type 1 from a root bus number that it tracks. For byte and halfword writes it runs a read-modify-write sequence. It gives up on a completion after a bounded number of polls.

Accesses that cannot reach a device are refused before anything is transmitted. A refused read returns all ones. Only one request is in flight at a time: a request is acknowledged, `busy` stays high while it runs, and a one-cycle `done` with `err` closes it.

Top module: `cfg_tlp_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `req_ack`, `tx_data_we`, `tx_ctrl_we` and `rx_poll` are low and the tracked root bus is 0.
- R2: A request seen in idle is acknowledged by a one-cycle `req_ack` in the following cycle. `busy` stays high until the cycle after a one-cycle `done`. `req_valid` is ignored while `busy` is high: no acknowledge, no TLP, no state change.
- R3: Header DW0 is {fmt/type, 24'h000001}. Fmt/type is 0x04 for a read and 0x44 for a write when the target bus equals the tracked root bus. It is 0x05 for a read and 0x45 for a write otherwise.
- R4: Header DW1 is {root bus, devfn, tag, 8'h0F}. The tag is 0x1D for reads and 0x10 for writes.
- R5: Header DW2 is {bus, devfn, 4'b0, offset[11:2], 2'b00}.
- R6: A TLP is sent in four cycles with one strobe each. First a data strobe carries reg0=DW0 and reg1=DW1, then a control strobe carries 2'b01. Next a data strobe carries reg0=DW2 and reg1=write data (zero for a read), then a control strobe carries 2'b10.
- R7: After the TLP, each `rx_poll` strobe is followed by a sample of `rx_eop` one cycle later. The first sample with `rx_eop` high completes the request. For a read, `rdata` is taken from `rx_reg0`.
- R8: If `rx_eop` is not seen within POLL_LIMIT (default 10) polls, the request ends with `err`=1 and `rdata`=32'hFFFFFFFF.
- R9: A size-1 read returns `(dw >> 8*offset[1:0]) & 8'hFF`. A size-2 read returns `(dw >> 16*offset[1]) & 16'hFFFF`. Any other size value is a full-dword access. A write that succeeds returns `rdata`=0.
- R10: A size-1 or size-2 write first sends a full-dword read. It then writes back that dword with the new byte or halfword inserted at shift 8*offset[1:0]. If the read times out, no write TLP is sent and `err`=1.
- R11: The access is refused with no strobe, `err`=1 and `rdata`=all ones in three cases. The first is a non-root bus with `link_state` equal to 0. The second is device number (devfn[7:3]) nonzero on the root bus. The third is device number nonzero when `req_primary` equals the root bus.
- R12: A write to the root bus at dword offset 0x18 sets the tracked root bus to the low byte of the written dword. The next request forms its header from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device (bits 7:3) and function (bits 2:0) |
| req_offset | input | 12 | Byte offset in configuration space |
| req_size | input | 3 | Access size in bytes: 1, 2, otherwise 4 |
| req_wdata | input | 32 | Write value (byte or halfword in low bits) |
| req_primary | input | 8 | Primary bus number of the target bus |
| link_state | input | 4 | Link state; zero means link down |
| req_ack | output | 1 | One-cycle request acknowledge |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Refused or timed out, valid with done |
| rdata | output | 32 | Read result, valid with done |
| tx_data_we | output | 1 | Load strobe for tx_reg0/tx_reg1 |
| tx_reg0 | output | 32 | Transmit data word 0 |
| tx_reg1 | output | 32 | Transmit data word 1 |
| tx_ctrl_we | output | 1 | Load strobe for tx_ctrl |
| tx_ctrl | output | 2 | Beat control: 01 start, 10 end |
| rx_poll | output | 1 | Completion sample strobe |
| rx_eop | input | 1 | Completion end-of-packet flag |
| rx_reg0 | input | 32 | Completion data word |

## Verification
The root bus update and header formation meet back to back. The update lands in the cycle a write to offset 0x18 on the root bus finishes, and the very next access already forms its DW0 and DW1 from the new value. The bench provokes this with a write of the primary-bus register followed at once by reads of the new and the old bus number. It judges the result by the Type 0 or Type 1 code and by the requester ID in the transmitted header. A second overlap is a fresh `req_valid` arriving while a slow completion is still being polled. It is judged by the absence of an acknowledge, by the TLP count, and by the root bus still being unchanged afterwards.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOAD, ST_B0D, ST_B0C, ST_B1D, ST_B1C, ST_POLL, ST_WAIT, ST_FIN
  } cfg_state_e;

  localparam logic [7:0] FT_RD0 = 8'h04;
  localparam logic [7:0] FT_WR0 = 8'h44;
  localparam logic [7:0] FT_RD1 = 8'h05;
  localparam logic [7:0] FT_WR1 = 8'h45;
  localparam logic [1:0] CTL_SOP = 2'b01;
  localparam logic [1:0] CTL_EOP = 2'b10;
endpackage

// File: rtl/cfg_hdr_build.sv
module cfg_hdr_build
  import cfg_tlp_pkg::*;
#(
  parameter logic [7:0] TAG_RD = 8'h1D,
  parameter logic [7:0] TAG_WR = 8'h10
) (
  input  logic [7:0]  bus,
  input  logic [7:0]  devfn,
  input  logic [11:0] offset,
  input  logic [7:0]  root,
  input  logic        is_write,
  output logic [31:0] dw0,
  output logic [31:0] dw1,
  output logic [31:0] dw2
);
  logic       local_bus;
  logic [7:0] fmt;

  always_comb begin
    local_bus = (bus == root);
    case ({local_bus, is_write})
      2'b11:   fmt = FT_WR0;
      2'b10:   fmt = FT_RD0;
      2'b01:   fmt = FT_WR1;
      default: fmt = FT_RD1;
    endcase
    dw0 = {fmt, 24'h000001};
    dw1 = {root, devfn, (is_write ? TAG_WR : TAG_RD), 8'h0F};
    dw2 = {bus, devfn, 4'b0000, offset[11:2], 2'b00};
  end
endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align (
  input  logic [2:0]  size,
  input  logic [1:0]  off,
  input  logic [31:0] dword,
  input  logic [31:0] wval,
  output logic [31:0] rd_out,
  output logic [31:0] merged
);
  logic [4:0]  sh;
  logic [31:0] mask;

  always_comb begin
    sh = {off, 3'b000};
    case (size)
      3'd1: begin
        rd_out = (dword >> sh) & 32'h0000_00FF;
        mask   = 32'h0000_00FF << sh;
        merged = (dword & ~mask) | ((wval & 32'h0000_00FF) << sh);
      end
      3'd2: begin
        rd_out = (dword >> {off[1], 4'b0000}) & 32'h0000_FFFF;
        mask   = 32'h0000_FFFF << sh;
        merged = (dword & ~mask) | ((wval & 32'h0000_FFFF) << sh);
      end
      default: begin
        rd_out = dword;
        mask   = 32'hFFFF_FFFF;
        merged = wval;
      end
    endcase
  end
endmodule

// File: rtl/cfg_access_filter.sv
module cfg_access_filter (
  input  logic [7:0] bus,
  input  logic [7:0] devfn,
  input  logic [7:0] primary,
  input  logic [7:0] root,
  input  logic [3:0] link_state,
  output logic       allow
);
  logic dev_nz, on_root, below_root, link_dn;

  always_comb begin
    dev_nz     = |devfn[7:3];
    on_root    = (bus == root);
    below_root = (primary == root);
    link_dn    = (link_state == 4'd0);
    allow = !((!on_root && link_dn) || (on_root && dev_nz) || (below_root && dev_nz));
  end
endmodule

// File: rtl/cfg_tlp_engine.sv
module cfg_tlp_engine
  import cfg_tlp_pkg::*;
#(
  parameter int         POLL_LIMIT      = 10,
  parameter logic [7:0] ROOT_BUS_INIT   = 8'h00,
  parameter logic [11:0] PRIMARY_REG_OFS = 12'h018,
  parameter logic [7:0] TAG_RD          = 8'h1D,
  parameter logic [7:0] TAG_WR          = 8'h10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_bus,
  input  logic [7:0]  req_devfn,
  input  logic [11:0] req_offset,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  input  logic [7:0]  req_primary,
  input  logic [3:0]  link_state,
  output logic        req_ack,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] rdata,
  output logic        tx_data_we,
  output logic [31:0] tx_reg0,
  output logic [31:0] tx_reg1,
  output logic        tx_ctrl_we,
  output logic [1:0]  tx_ctrl,
  output logic        rx_poll,
  input  logic        rx_eop,
  input  logic [31:0] rx_reg0
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] POLL_MAX = PW'(POLL_LIMIT);

  cfg_state_e  state;
  logic [7:0]  bus_q, devfn_q, prim_q, root_q;
  logic [11:0] off_q;
  logic [2:0]  size_q;
  logic [31:0] wdata_q;
  logic        cur_wr, rmw_q, second;
  logic [PW-1:0] polls;

  logic [31:0] dw0, dw1, dw2, rd_lane, merged;
  logic        allow, root_hit, full_sz;

  cfg_hdr_build #(.TAG_RD(TAG_RD), .TAG_WR(TAG_WR)) u_hdr (
    .bus(bus_q), .devfn(devfn_q), .offset(off_q), .root(root_q),
    .is_write(cur_wr), .dw0(dw0), .dw1(dw1), .dw2(dw2)
  );

  cfg_lane_align u_lane (
    .size(size_q), .off(off_q[1:0]), .dword(rx_reg0), .wval(wdata_q),
    .rd_out(rd_lane), .merged(merged)
  );

  cfg_access_filter u_filt (
    .bus(bus_q), .devfn(devfn_q), .primary(prim_q), .root(root_q),
    .link_state(link_state), .allow(allow)
  );

  assign full_sz  = !(req_size == 3'd1 || req_size == 3'd2);
  assign root_hit = (bus_q == root_q) && (off_q[11:2] == PRIMARY_REG_OFS[11:2]);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_ack    <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      rdata      <= '0;
      tx_data_we <= 1'b0;
      tx_ctrl_we <= 1'b0;
      tx_reg0    <= '0;
      tx_reg1    <= '0;
      tx_ctrl    <= '0;
      rx_poll    <= 1'b0;
      root_q     <= ROOT_BUS_INIT;
      bus_q      <= '0;
      devfn_q    <= '0;
      prim_q     <= '0;
      off_q      <= '0;
      size_q     <= '0;
      wdata_q    <= '0;
      cur_wr     <= 1'b0;
      rmw_q      <= 1'b0;
      second     <= 1'b0;
      polls      <= '0;
    end else begin
      req_ack    <= 1'b0;
      done       <= 1'b0;
      tx_data_we <= 1'b0;
      tx_ctrl_we <= 1'b0;
      rx_poll    <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          req_ack <= 1'b1;
          bus_q   <= req_bus;
          devfn_q <= req_devfn;
          prim_q  <= req_primary;
          off_q   <= req_offset;
          size_q  <= req_size;
          wdata_q <= req_wdata;
          cur_wr  <= req_write && full_sz;
          rmw_q   <= req_write && !full_sz;
          second  <= 1'b0;
          state   <= ST_LOAD;
        end
        ST_LOAD: begin
          if (!second && !allow) begin
            err   <= 1'b1;
            rdata <= '1;
            done  <= 1'b1;
            state <= ST_FIN;
          end else begin
            tx_data_we <= 1'b1;
            tx_reg0    <= dw0;
            tx_reg1    <= dw1;
            polls      <= '0;
            state      <= ST_B0D;
          end
        end
        ST_B0D: begin
          tx_ctrl_we <= 1'b1;
          tx_ctrl    <= CTL_SOP;
          state      <= ST_B0C;
        end
        ST_B0C: begin
          tx_data_we <= 1'b1;
          tx_reg0    <= dw2;
          tx_reg1    <= cur_wr ? wdata_q : 32'h0;
          state      <= ST_B1D;
        end
        ST_B1D: begin
          tx_ctrl_we <= 1'b1;
          tx_ctrl    <= CTL_EOP;
          state      <= ST_B1C;
        end
        ST_B1C: begin
          rx_poll <= 1'b1;
          polls   <= polls + 1'b1;
          state   <= ST_POLL;
        end
        ST_POLL: state <= ST_WAIT;
        ST_WAIT: begin
          if (rx_eop || polls == POLL_MAX) begin
            if (cur_wr && root_hit) root_q <= wdata_q[7:0];
            if (rx_eop && !cur_wr && rmw_q) begin
              wdata_q <= merged;
              cur_wr  <= 1'b1;
              second  <= 1'b1;
              state   <= ST_LOAD;
            end else begin
              done  <= 1'b1;
              err   <= !rx_eop;
              rdata <= !rx_eop ? 32'hFFFF_FFFF : (cur_wr ? 32'h0 : rd_lane);
              state <= ST_FIN;
            end
          end else begin
            rx_poll <= 1'b1;
            polls   <= polls + 1'b1;
            state   <= ST_POLL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: each control word is preceded by its data load
  a_r6_ctrl_after_data: assert property (@(posedge clk) disable iff (rst)
    tx_ctrl_we |-> $past(tx_data_we));
  // R6: transmit and poll strobes never overlap
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_data_we, tx_ctrl_we, rx_poll}));
  // R2: done is a single pulse and the engine is idle after it
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
  // R2: acknowledge only for a request taken while idle
  a_r2_ack_idle: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> $past(!busy));
  // R8: poll counter stays within its limit
  a_r8_poll_bound: assert property (@(posedge clk) disable iff (rst)
    polls <= POLL_MAX);
  // R8: an error completion reports all ones
  a_r8_err_ones: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (rdata == 32'hFFFF_FFFF));
endmodule

// File: tb/tb_cfg_tlp_engine.sv
module tb_cfg_tlp_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_bus = 0, req_devfn = 0, req_primary = 8'hFF;
  logic [11:0] req_offset = 0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = 0;
  logic [3:0]  link_state = 4'h1;
  logic        req_ack, busy, done, err;
  logic [31:0] rdata;
  logic        tx_data_we, tx_ctrl_we, rx_poll;
  logic [31:0] tx_reg0, tx_reg1;
  logic [1:0]  tx_ctrl;
  logic        rx_eop = 0;
  logic [31:0] rx_reg0 = 0;

  cfg_tlp_engine dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
    .req_size(req_size), .req_wdata(req_wdata), .req_primary(req_primary),
    .link_state(link_state), .req_ack(req_ack), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .tx_data_we(tx_data_we), .tx_reg0(tx_reg0),
    .tx_reg1(tx_reg1), .tx_ctrl_we(tx_ctrl_we), .tx_ctrl(tx_ctrl),
    .rx_poll(rx_poll), .rx_eop(rx_eop), .rx_reg0(rx_reg0)
  );

  int checks = 0, errors = 0;
  int tlp_cnt = 0, poll_total = 0, poll_in_tlp = 0, resp_at = 1;
  int sop_cnt = 0;
  logic in_b1 = 0;
  logic [31:0] m_b0r0, m_b0r1, m_b1r0, m_b1r1;
  logic [31:0] r_data;
  logic r_err, r_ack, r_busy;
  int d_tlp, d_poll;

  // transmit monitor and completion responder
  always @(negedge clk) if (!rst) begin
    if (tx_data_we) begin
      if (!in_b1) begin m_b0r0 = tx_reg0; m_b0r1 = tx_reg1; end
      else begin m_b1r0 = tx_reg0; m_b1r1 = tx_reg1; end
    end
    if (tx_ctrl_we) begin
      if (tx_ctrl == 2'b01) begin in_b1 = 1; sop_cnt++; end
      else if (tx_ctrl == 2'b10) begin in_b1 = 0; tlp_cnt++; poll_in_tlp = 0; end
    end
    if (rx_poll) begin
      poll_in_tlp++;
      poll_total++;
      rx_eop = (resp_at != 0) && (poll_in_tlp >= resp_at);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
                        input logic [11:0] off, input logic [2:0] sz,
                        input logic [31:0] wd, input logic [7:0] prim);
    int t0, p0;
    t0 = tlp_cnt; p0 = poll_total;
    @(negedge clk);
    req_write = wr; req_bus = bus; req_devfn = devfn; req_offset = off;
    req_size = sz; req_wdata = wd; req_primary = prim; req_valid = 1;
    @(negedge clk);
    r_ack = req_ack; req_valid = 0;
    while (!done) @(negedge clk);
    r_data = rdata; r_err = err;
    @(negedge clk);
    r_busy = busy;
    d_tlp = tlp_cnt - t0; d_poll = poll_total - p0;
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 done/err/ack", {29'b0, done, err, req_ack}, 0);
    chk("R1 strobes", {29'b0, tx_data_we, tx_ctrl_we, rx_poll}, 0);
  endtask

  task automatic t_type0_read;
    resp_at = 1; rx_reg0 = 32'h1234_5678;
    do_req(0, 8'h00, 8'h00, 12'h010, 3'd4, 0, 8'hFF);
    chk("R2 ack", {31'b0, r_ack}, 1);
    chk("R2 idle after done", {31'b0, r_busy}, 0);
    chk("R3 type0 read dw0", m_b0r0, 32'h0400_0001);
    chk("R4 read dw1", m_b0r1, 32'h0000_1D0F);
    chk("R5 dw2", m_b1r0, 32'h0000_0010);
    chk("R6 read beat1 data", m_b1r1, 0);
    chk("R6 one tlp", d_tlp, 1);
    chk("R7 read data", r_data, 32'h1234_5678);
    chk("R7 err", {31'b0, r_err}, 0);
  endtask

  task automatic t_type1_half_read;
    resp_at = 4; rx_reg0 = 32'hBEEF_1234;
    do_req(0, 8'h03, 8'h0A, 12'h00E, 3'd2, 0, 8'h01);
    chk("R3 type1 read dw0", m_b0r0, 32'h0500_0001);
    chk("R4 requester id", m_b0r1, 32'h000A_1D0F);
    chk("R5 aligned offset", m_b1r0, 32'h030A_000C);
    chk("R7 polls until eop", d_poll, 4);
    chk("R9 halfword read", r_data, 32'h0000_BEEF);
  endtask

  task automatic t_byte_read;
    resp_at = 2; rx_reg0 = 32'hA1B2_C3D4;
    do_req(0, 8'h00, 8'h00, 12'h00B, 3'd1, 0, 8'hFF);
    chk("R9 byte read lane3", r_data, 32'h0000_00A1);
    do_req(0, 8'h00, 8'h00, 12'h009, 3'd1, 0, 8'hFF);
    chk("R9 byte read lane1", r_data, 32'h0000_00C3);
  endtask

  task automatic t_full_write;
    resp_at = 1;
    do_req(1, 8'h02, 8'h00, 12'h040, 3'd4, 32'hCAFE_F00D, 8'h00);
    chk("R3 type1 write dw0", m_b0r0, 32'h4500_0001);
    chk("R4 write tag", m_b0r1, 32'h0000_100F);
    chk("R5 write dw2", m_b1r0, 32'h0200_0040);
    chk("R6 write data beat", m_b1r1, 32'hCAFE_F00D);
    chk("R9 write rdata zero", r_data, 0);
    chk("R6 sop count", sop_cnt, 5);
  endtask

  task automatic t_rmw;
    resp_at = 1; rx_reg0 = 32'h1122_3344;
    do_req(1, 8'h00, 8'h00, 12'h005, 3'd1, 32'h0000_005A, 8'hFF);
    chk("R10 two tlps", d_tlp, 2);
    chk("R10 write dw0", m_b0r0, 32'h4400_0001);
    chk("R10 write dw2", m_b1r0, 32'h0000_0004);
    chk("R10 merged byte", m_b1r1, 32'h1122_5A44);
    chk("R10 err", {31'b0, r_err}, 0);
    do_req(1, 8'h00, 8'h00, 12'h002, 3'd2, 32'h0000_ABCD, 8'hFF);
    chk("R10 merged half", m_b1r1, 32'hABCD_3344);
  endtask

  task automatic t_timeouts;
    resp_at = 0;
    do_req(0, 8'h00, 8'h00, 12'h020, 3'd4, 0, 8'hFF);
    chk("R8 timeout err", {31'b0, r_err}, 1);
    chk("R8 timeout data", r_data, 32'hFFFF_FFFF);
    chk("R8 poll count", d_poll, 10);
    do_req(1, 8'h00, 8'h00, 12'h021, 3'd1, 32'h77, 8'hFF);
    chk("R10 abort single tlp", d_tlp, 1);
    chk("R10 abort err", {31'b0, r_err}, 1);
    resp_at = 1;
  endtask

  task automatic t_filter;
    link_state = 4'h0;
    do_req(0, 8'h01, 8'h00, 12'h000, 3'd4, 0, 8'hFF);
    chk("R11 link down no tlp", d_tlp, 0);
    chk("R11 link down ones", r_data, 32'hFFFF_FFFF);
    chk("R11 link down err", {31'b0, r_err}, 1);
    rx_reg0 = 32'h0000_1AF4;
    do_req(0, 8'h00, 8'h00, 12'h000, 3'd4, 0, 8'hFF);
    chk("R11 root bus needs no link", {d_tlp[30:0], r_err}, 32'h2);
    link_state = 4'h1;
    do_req(0, 8'h00, 8'h08, 12'h000, 3'd4, 0, 8'hFF);
    chk("R11 root dev1 refused", {d_tlp[30:0], r_err}, 32'h1);
    do_req(1, 8'h05, 8'h10, 12'h000, 3'd4, 32'h1, 8'h00);
    chk("R11 below root dev2 refused", {d_tlp[30:0], r_err}, 32'h1);
  endtask

  task automatic t_root_track;
    resp_at = 1;
    do_req(1, 8'h00, 8'h00, 12'h018, 3'd4, 32'h0000_0907, 8'hFF);
    do_req(0, 8'h07, 8'h00, 12'h000, 3'd4, 0, 8'hFF);
    chk("R12 new root type0", m_b0r0, 32'h0400_0001);
    chk("R12 new root requester", m_b0r1, 32'h0700_1D0F);
    do_req(0, 8'h00, 8'h00, 12'h000, 3'd4, 0, 8'hFF);
    chk("R12 old root now type1", m_b0r0, 32'h0500_0001);
    do_req(1, 8'h07, 8'h00, 12'h018, 3'd4, 32'h0000_0000, 8'hFF);
    do_req(0, 8'h00, 8'h00, 12'h000, 3'd4, 0, 8'hFF);
    chk("R12 root restored", m_b0r0, 32'h0400_0001);
  endtask

  task automatic t_busy_ignore;
    int t0, acks;
    resp_at = 6; t0 = tlp_cnt; acks = 0;
    @(negedge clk);
    req_write = 0; req_bus = 0; req_devfn = 0; req_offset = 12'h030;
    req_size = 3'd4; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (8) @(negedge clk);
    req_write = 1; req_offset = 12'h018; req_wdata = 32'h55; req_valid = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (req_ack) acks++;
    end
    req_valid = 0;
    while (!done) begin
      @(negedge clk);
      if (req_ack) acks++;
    end
    @(negedge clk);
    chk("R2 no ack while busy", acks, 0);
    chk("R2 single tlp while busy", tlp_cnt - t0, 1);
    resp_at = 1;
    do_req(0, 8'h00, 8'h00, 12'h000, 3'd4, 0, 8'hFF);
    chk("R2 ignored write left root", m_b0r0, 32'h0400_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_type0_read();
    t_type1_half_read();
    t_byte_read();
    t_full_write();
    t_rmw();
    t_timeouts();
    t_filter();
    t_root_track();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule